// File: doc/BRIEF.md
# Pin Wake-Up Edge Controller

This block watches a group of eight asynchronous pins and turns selected edges on them into a wake-up or interrupt request. Each pin is first passed through a two-flop synchronizer. The block then compares the synchronized value with its value one cycle earlier to find edges. Software picks the edge for each pin with two control bits. One bit chooses rising or falling. A second bit, when set, overrides the first and makes both edges count.

A detected edge sets a sticky per-pin sense flag. Software clears these flags by writing ones. The flags are masked by a per-pin enable, ORed across the group, and registered onto `wake_o`. Four byte-wide registers sit on a simple single-cycle register bus, with a write strobe and a combinational read. Bit n of every register belongs to pin n. A parameter can build the group without an enable register. In that build every pin is permanently enabled.

Top module: `pin_wake_ctrl`

## Requirements
- R1: All registers reset to 0. Address 0 holds the polarity bits and address 1 the both-edge bits. Address 3 holds the enable bits when the enable register is present. Each of these reads back what was last written, and address 2 reads the sense flags.
- R2: With both-edge bit n at 0 and polarity bit n at 0, a low-to-high transition on pin n sets sense flag n, and a high-to-low transition does not.
- R3: With both-edge bit n at 0 and polarity bit n at 1, a high-to-low transition on pin n sets sense flag n, and a low-to-high transition does not.
- R4: With both-edge bit n at 1, either transition on pin n sets sense flag n, whatever the polarity bit holds.
- R5: Sense flags are sticky. A write to address 2 clears exactly the flags whose data bit is 1, and leaves the other flags as they were.
- R6: If an edge on pin n is detected in the same cycle as a write of 1 to flag n, the flag is 1 afterwards.
- R7: A sense flag sets whether or not its pin is enabled. A disabled pin's flag does not drive `wake_o`.
- R8: `wake_o` is a register holding the OR over all pins of (sense flag AND enable). A pin level applied before clock edge k shows in its flag after edge k+2 and in `wake_o` after edge k+3.
- R9: With HAS_ENABLE = 0, every pin counts as enabled and address 3 reads 0xFF. A write to address 3 has no effect.
- R10: Reading any register, including the sense flags, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous wake pins |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| wake_o | output | 1 | Registered wake/interrupt request |

## Verification
The hardest case to reach is R6, where a detected edge and a clearing write land on the same flag in the same cycle. The pin travels through a synchronizer and an edge stage first. The bench changes the pin on a falling clock edge, counts two rising edges, and then raises the clearing write so that it is sampled on the third edge. That third edge is the one where the flag would set. The same exact count is used to check the R8 latency of the flag and of `wake_o`.

// File: rtl/pwk_pkg.sv
package pwk_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_POL  = 2'd0,
    REG_BOTH = 2'd1,
    REG_SNS  = 2'd2,
    REG_EN   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwk_sync.sv
module pwk_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwk_edge.sv
module pwk_edge #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] both_i,
  output logic [W-1:0] det_o
);
  logic [W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else dly_q <= sync_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise = sync_i[i] & ~dly_q[i];
    assign fall = ~sync_i[i] & dly_q[i];
    // both-edge bit overrides polarity
    assign det_o[i] = both_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);
  end
endmodule

// File: rtl/pwk_regs.sv
module pwk_regs
  import pwk_pkg::*;
#(
  parameter int W          = 8,
  parameter bit HAS_ENABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      det_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      both_o,
  output logic [W-1:0]      sns_o,
  output logic [W-1:0]      en_o
);
  logic [W-1:0] pol_q, both_q, sns_q, en_q, clr;

  assign clr = (wr_i && addr_i == REG_SNS) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      both_q <= '0;
      sns_q  <= '0;
    end else begin
      if (wr_i && addr_i == REG_POL)  pol_q  <= wdata_i;
      if (wr_i && addr_i == REG_BOTH) both_q <= wdata_i;
      sns_q <= (sns_q & ~clr) | det_i;  // set beats clear
    end
  end

  if (HAS_ENABLE) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= '0;
      else if (wr_i && addr_i == REG_EN) en_q <= wdata_i;
    end
  end else begin : g_no_en
    assign en_q = '1;
  end

  always_comb begin
    unique case (addr_i)
      REG_POL:  rdata_o = pol_q;
      REG_BOTH: rdata_o = both_q;
      REG_SNS:  rdata_o = sns_q;
      default:  rdata_o = en_q;
    endcase
  end

  assign pol_o  = pol_q;
  assign both_o = both_q;
  assign sns_o  = sns_q;
  assign en_o   = en_q;

  // R5: written ones without a coincident edge are cleared
  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_SNS && (wdata_i & ~det_i) != '0)
    |=> ((sns_q & $past(wdata_i & ~det_i)) == '0));

  // R5: flags not written as one stay set
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sns_q & $past(sns_q & ~clr)) == $past(sns_q & ~clr)));

  // R2: a flag only rises because of a detected edge
  a_r2_set_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sns_q & ~$past(sns_q) & ~$past(det_i)) == '0));

  // R6: a detected edge always leaves its flag set
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i != '0) |=> ((sns_q & $past(det_i)) == $past(det_i)));
endmodule

// File: rtl/pin_wake_ctrl.sv
module pin_wake_ctrl
  import pwk_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STG   = 2,
  parameter bit HAS_ENABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      pin_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              wake_o
);
  logic [W-1:0] sync, pol, both, sns, en, det;
  logic         wake_q;

  pwk_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync)
  );

  pwk_edge #(.W(W)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync),
    .pol_i(pol), .both_i(both), .det_o(det)
  );

  pwk_regs #(.W(W), .HAS_ENABLE(HAS_ENABLE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .det_i(det), .rdata_o(rdata_o),
    .pol_o(pol), .both_o(both), .sns_o(sns), .en_o(en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else wake_q <= |(sns & en);
  end

  assign wake_o = wake_q;

  // R8 / R7: wake follows masked flags one cycle later
  a_r8_wake_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (wake_o == ($past(sns & en) != '0)));
endmodule

// File: tb/pin_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pin_wake_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata_ne;
  logic       wake, wake_ne;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pin_wake_ctrl u_pin_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .wake_o(wake)
  );

  pin_wake_ctrl #(.HAS_ENABLE(1'b0)) u_pin_wake_ctrl_noen (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_ne), .wake_o(wake_ne)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    cyc(1);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 pol reset", 2'd0, 8'h00);
    rd_chk("R1 both reset", 2'd1, 8'h00);
    rd_chk("R1 sns reset", 2'd2, 8'h00);
    rd_chk("R1 en reset", 2'd3, 8'h00);
    chk("R1 wake reset", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_regs;
    wr_reg(2'd0, 8'hA5); rd_chk("R1 pol rw", 2'd0, 8'hA5);
    wr_reg(2'd1, 8'h3C); rd_chk("R1 both rw", 2'd1, 8'h3C);
    wr_reg(2'd3, 8'h5A); rd_chk("R1 en rw", 2'd3, 8'h5A);
    wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'h00); wr_reg(2'd3, 8'h00);
  endtask

  task automatic t_rising;  // R2 and R8 latency
    wr_reg(2'd3, 8'h01);
    pins[0] = 1'b1;
    cyc(2); rd_chk("R8 flag not yet", 2'd2, 8'h00);
    cyc(1); rd_chk("R2 rise sets", 2'd2, 8'h01);
    chk("R8 wake not yet", {7'd0, wake}, 8'h00);
    cyc(1); chk("R8 wake set", {7'd0, wake}, 8'h01);
    wr_reg(2'd2, 8'h01); cyc(1);
    pins[0] = 1'b0; cyc(4);
    rd_chk("R2 fall ignored", 2'd2, 8'h00);
    chk("R8 wake cleared", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_falling;  // R3
    wr_reg(2'd0, 8'h02);
    pins[1] = 1'b1; cyc(4);
    rd_chk("R3 rise ignored", 2'd2, 8'h00);
    pins[1] = 1'b0; cyc(4);
    rd_chk("R3 fall sets", 2'd2, 8'h02);
    wr_reg(2'd2, 8'hFF);
  endtask

  task automatic t_both;  // R4 with polarity also set
    wr_reg(2'd1, 8'h04); wr_reg(2'd0, 8'h06);
    pins[2] = 1'b1; cyc(4);
    rd_chk("R4 rise sets", 2'd2, 8'h04);
    wr_reg(2'd2, 8'h04);
    pins[2] = 1'b0; cyc(4);
    rd_chk("R4 fall sets", 2'd2, 8'h04);
    wr_reg(2'd2, 8'h04);
  endtask

  task automatic t_w1c;  // R5 and R10
    wr_reg(2'd1, 8'h30);
    pins[5:4] = 2'b11; cyc(4);
    rd_chk("R5 two flags", 2'd2, 8'h30);
    cyc(2); rd_chk("R10 read no side effect", 2'd2, 8'h30);
    wr_reg(2'd2, 8'h00); rd_chk("R5 zero write no effect", 2'd2, 8'h30);
    wr_reg(2'd2, 8'h10); rd_chk("R5 partial clear", 2'd2, 8'h20);
    wr_reg(2'd2, 8'h20); rd_chk("R5 full clear", 2'd2, 8'h00);
  endtask

  task automatic t_set_wins;  // R6: flag 4 already set, opposite edge coincides with clear
    pins[4] = 1'b0; cyc(4);
    rd_chk("R6 pre set", 2'd2, 8'h10);
    pins[4] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr = 1'b1; addr = 2'd2; wdata = 8'h10;
    cyc(1);
    wr = 1'b0;
    rd_chk("R6 set wins", 2'd2, 8'h10);
    wr_reg(2'd2, 8'h10); rd_chk("R6 clear after", 2'd2, 8'h00);
  endtask

  task automatic t_enable_mask;  // R7
    wr_reg(2'd3, 8'h00);
    pins[5] = 1'b0; cyc(5);
    rd_chk("R7 disabled flag sets", 2'd2, 8'h20);
    chk("R7 disabled no wake", {7'd0, wake}, 8'h00);
    wr_reg(2'd3, 8'h20); cyc(1);
    chk("R7 enable exposes flag", {7'd0, wake}, 8'h01);
    wr_reg(2'd2, 8'hFF); cyc(1);
  endtask

  task automatic t_noen;  // R9
    wr_reg(2'd3, 8'h00);
    addr = 2'd3; #1; chk("R9 en reads ones", rdata_ne, 8'hFF);
    chk("R9 cleared no wake", {7'd0, wake_ne}, 8'h00);
    wr_reg(2'd1, 8'h80);
    pins[7] = 1'b1; cyc(5);
    chk("R9 always enabled wake", {7'd0, wake_ne}, 8'h01);
    chk("R9 main disabled", {7'd0, wake}, 8'h00);
    addr = 2'd3; #1; chk("R9 write ignored", rdata_ne, 8'hFF);
  endtask

  initial begin
    cyc(2);
    t_reset();
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_rising();
    t_falling();
    t_both();
    t_w1c();
    t_set_wins();
    t_enable_mask();
    t_noen();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule